// File: doc/BRIEF.md
# Interrupt Source Trigger/Acknowledge State Array

This block keeps a two-bit state for each of a small set of interrupt sources and lets software and hardware steer that state through memory-mapped accesses that have side effects. Each source owns two pages: a trigger page, where any store fires the source, and a management page, where loads read or force the state and a store at one offset signals end-of-interrupt. The state bits are written here as `{P,Q}`: P marks an event already forwarded and not yet ended, Q marks a trigger that arrived in the meantime.

When a trigger is accepted, or when an end-of-interrupt finds a queued trigger, the block emits a one-cycle forward event carrying the source index to the routing stage downstream. Triggers that arrive while an event is outstanding are coalesced into Q, and a source in the off state drops triggers. Requests arrive on a simple single-beat port; loads are answered exactly one cycle later, stores get no answer.

Top module: `pqsrc_top`

## Requirements
- R1: After reset every source is in the off state `{P,Q}=01`, and `rsp_valid` and `evt_valid` are low.
- R2: An address is decoded as offset = bits [11:0], page select = bit 12 (0 trigger, 1 management), source index = bits [15:13]; the management operation code is offset bits [11:8], and offset bits [7:0] must be zero for a management access to take effect.
- R3: A load on the management page with operation code 8, 9, 10 or 11 sets `{P,Q}` to the two low bits of the code and returns the previous `{P,Q}`.
- R4: A load on the management page with any other operation code (for example 0) returns the current `{P,Q}` and leaves it unchanged.
- R5: A store to the trigger page of a source in state 00 moves it to 10 and pulses `evt_valid` with `evt_src` equal to the source index in the cycle after the request.
- R6: A store to the trigger page of a source in state 10 or 11 leaves it in 11 and forwards nothing.
- R7: A store to the trigger page of a source in state 01 changes nothing and forwards nothing.
- R8: A store to the management page with operation code 4 (end-of-interrupt) moves 10 to 00 with no event, moves 11 to 10 and forwards a fresh event, and leaves 00 and 01 unchanged.
- R9: Every load is answered by a one-cycle `rsp_valid` pulse in the cycle after the request, with `{P,Q}` in `rsp_data[1:0]` and zeros above; stores never raise `rsp_valid`; loads on the trigger page and misaligned management loads return zero and change nothing.
- R10: Management stores with an operation code other than 4, or with nonzero offset bits [7:0], change nothing and forward nothing.
- R11: An access changes only the state of the addressed source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | 16 | Request address (index, page, offset) |
| rsp_valid | output | 1 | Load answer valid |
| rsp_data | output | 8 | Load answer, state in bits [1:0] |
| evt_valid | output | 1 | Forward event pulse |
| evt_src | output | 3 | Index of the source forwarded |

## Verification
A corrupted state register shows up at the ports one request later: the next inspection load of that source returns the wrong `{P,Q}`, and a wrong state also changes whether the next trigger or end-of-interrupt raises `evt_valid`. A decode fault shows as the wrong source changing, which a load to a neighbouring source exposes in the cycle after it is issued. A lost or duplicated forward event is visible directly on `evt_valid` one cycle after the offending store.

// File: rtl/pqsrc_pkg.sv
// Package: shared encodings and the per-source next-state rule.
// Assumes one request per cycle; the rule is pure combinational logic.
package pqsrc_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_TRIG,
        CMD_EOI,
        CMD_SET,
        CMD_PEEK
    } cmd_e;

    localparam logic [1:0] PQ_RESET  = 2'b00;
    localparam logic [1:0] PQ_OFF    = 2'b01;
    localparam logic [1:0] PQ_PEND   = 2'b10;
    localparam logic [1:0] PQ_QUEUED = 2'b11;

    localparam logic [3:0] OP_EOI    = 4'h4;
    localparam logic [1:0] OP_SETGRP = 2'b10;

    typedef struct packed {
        logic       fwd;
        logic [1:0] pq;
    } step_t;

    // Next state and forward flag for one source given a command.
    function automatic step_t pq_step(input logic [1:0] cur, input cmd_e cmd,
                                      input logic [1:0] setv);
        step_t r;
        r.fwd = 1'b0;
        r.pq  = cur;
        unique case (cmd)
            CMD_TRIG: begin
                unique case (cur)
                    PQ_RESET:  begin r.pq = PQ_PEND; r.fwd = 1'b1; end
                    PQ_PEND:   r.pq = PQ_QUEUED;
                    PQ_QUEUED: r.pq = PQ_QUEUED;
                    default:   r.pq = cur;
                endcase
            end
            CMD_EOI: begin
                unique case (cur)
                    PQ_PEND:   r.pq = PQ_RESET;
                    PQ_QUEUED: begin r.pq = PQ_PEND; r.fwd = 1'b1; end
                    default:   r.pq = cur;
                endcase
            end
            CMD_SET:  r.pq = setv;
            default:  r.pq = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pqsrc_decode.sv
// Decoder: splits a request address into source index, page and
// operation and turns it into one command. Assumes ADDR_W equals
// PAGE_SHIFT + 1 + SRC_W and PAGE_SHIFT >= 5.
module pqsrc_decode
    import pqsrc_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int SRC_W      = 3,
    parameter int ADDR_W     = PAGE_SHIFT + 1 + SRC_W
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [SRC_W-1:0]  dec_idx,
    output logic              dec_hit,
    output logic              dec_mgmt_ok,
    output cmd_e              dec_cmd,
    output logic [1:0]        dec_setv
);

    localparam int OP_LSB  = PAGE_SHIFT - 4;
    localparam int LOW_W   = OP_LSB;

    logic [3:0] op;
    logic       page_mgmt;
    logic       low_zero;
    logic       in_range;

    // Field extraction from the address.
    always_comb begin
        dec_idx   = req_addr[PAGE_SHIFT+1 +: SRC_W];
        page_mgmt = req_addr[PAGE_SHIFT];
        op        = req_addr[OP_LSB +: 4];
        low_zero  = ~|req_addr[LOW_W-1:0];
        in_range  = ({1'b0, dec_idx} < (SRC_W+1)'(NUM_SRC));
        dec_hit   = req_valid && in_range;
        dec_setv  = op[1:0];
    end

    // Command selection from page, direction and operation code.
    always_comb begin
        dec_cmd     = CMD_NONE;
        dec_mgmt_ok = 1'b0;
        if (dec_hit) begin
            if (!page_mgmt) begin
                if (req_write) dec_cmd = CMD_TRIG;
            end else if (low_zero) begin
                dec_mgmt_ok = 1'b1;
                if (req_write) begin
                    if (op == OP_EOI) dec_cmd = CMD_EOI;
                end else if (op[3:2] == OP_SETGRP) begin
                    dec_cmd = CMD_SET;
                end else begin
                    dec_cmd = CMD_PEEK;
                end
            end
        end
    end

endmodule

// File: rtl/pqsrc_cell.sv
// State cell: holds {P,Q} for one source and applies the command
// when selected. Assumes at most one command per cycle.
module pqsrc_cell
    import pqsrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  cmd_e       cmd,
    input  logic [1:0] setv,
    output logic [1:0] pq,
    output logic       fwd
);

    step_t nxt;

    // Next state from the shared rule, masked by selection.
    always_comb begin
        nxt = pq_step(pq, sel ? cmd : CMD_NONE, setv);
        fwd = nxt.fwd;
    end

    // State register, off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pq <= PQ_OFF;
        else        pq <= nxt.pq;
    end

endmodule

// File: rtl/pqsrc_resp.sv
// Output stage: registers the load answer and the forward event so
// both appear one cycle after the request.
module pqsrc_resp #(
    parameter int DATA_W = 8,
    parameter int SRC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [1:0]        ld_pq,
    input  logic              ev_req,
    input  logic [SRC_W-1:0]  ev_idx,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              evt_valid,
    output logic [SRC_W-1:0]  evt_src
);

    localparam int PAD_W = DATA_W - 2;

    // Load answer register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= ld_req;
            rsp_data  <= ld_req ? {{PAD_W{1'b0}}, ld_pq} : '0;
        end
    end

    // Forward event register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_src   <= '0;
        end else begin
            evt_valid <= ev_req;
            evt_src   <= ev_req ? ev_idx : '0;
        end
    end

endmodule

// File: rtl/pqsrc_top.sv
// Top: array of per-source trigger/acknowledge state cells behind an
// address decoder and a registered answer/event stage.
// Assumes a single-beat request port with one request per cycle.
module pqsrc_top
    import pqsrc_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int DATA_W     = 8,
    parameter int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter int ADDR_W     = PAGE_SHIFT + 1 + SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              evt_valid,
    output logic [SRC_W-1:0]  evt_src
);

    logic [SRC_W-1:0] dec_idx;
    logic             dec_hit;
    logic             dec_mgmt_ok;
    cmd_e             dec_cmd;
    logic [1:0]       dec_setv;

    logic [1:0]       pq_all [NUM_SRC];
    logic [NUM_SRC-1:0] fwd_vec;
    logic [1:0]       sel_pq;
    logic             ld_req;

    pqsrc_decode #(
        .NUM_SRC   (NUM_SRC),
        .PAGE_SHIFT(PAGE_SHIFT),
        .SRC_W     (SRC_W),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .dec_idx    (dec_idx),
        .dec_hit    (dec_hit),
        .dec_mgmt_ok(dec_mgmt_ok),
        .dec_cmd    (dec_cmd),
        .dec_setv   (dec_setv)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        pqsrc_cell u_cell (
            .clk (clk),
            .rst_n(rst_n),
            .sel (dec_hit && (dec_idx == SRC_W'(g))),
            .cmd (dec_cmd),
            .setv(dec_setv),
            .pq  (pq_all[g]),
            .fwd (fwd_vec[g])
        );
    end

    // Old state of the addressed source, zero when not a management load.
    always_comb begin
        sel_pq = 2'b00;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (dec_idx == SRC_W'(i) && dec_hit && dec_mgmt_ok) sel_pq = pq_all[i];
        end
        ld_req = req_valid && !req_write;
    end

    pqsrc_resp #(
        .DATA_W(DATA_W),
        .SRC_W (SRC_W)
    ) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_req   (ld_req),
        .ld_pq    (sel_pq),
        .ev_req   (|fwd_vec),
        .ev_idx   (dec_idx),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .evt_valid(evt_valid),
        .evt_src  (evt_src)
    );

endmodule

// File: rtl/pqsrc_chk.sv
// Checker: protocol and state properties of the source array, bound
// into the top module.
module pqsrc_chk
    import pqsrc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             rsp_valid,
    input logic             evt_valid,
    input logic [SRC_W-1:0] evt_src,
    input logic [1:0]       pq_all [NUM_SRC]
);

    logic [1:0] prev_pq [NUM_SRC];

    // Copy of each state from the previous cycle.
    always_ff @(posedge clk) prev_pq <= pq_all;

    // R9
    load_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R9
    no_store_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R5
    evt_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(req_valid && req_write));

    // R5
    evt_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (pq_all[evt_src] == PQ_PEND));

    // R7
    evt_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (prev_pq[evt_src] == PQ_RESET || prev_pq[evt_src] == PQ_QUEUED));

endmodule

bind pqsrc_top pqsrc_chk #(
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .rsp_valid(rsp_valid),
    .evt_valid(evt_valid),
    .evt_src  (evt_src),
    .pq_all   (pq_all)
);

// File: tb/pqsrc_top_tb.sv
module pqsrc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        evt_valid;
    logic [2:0]  evt_src;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pqsrc_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .evt_valid(evt_valid),
        .evt_src  (evt_src)
    );

    function automatic logic [15:0] mk(input int src, input bit mgmt, input logic [3:0] op);
        return 16'((src << 13) | (int'(mgmt) << 12) | (int'(op) << 8));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One access; outputs captured the cycle after the request.
    task automatic acc(input bit wr, input logic [15:0] a,
                       output logic rv, output logic [7:0] rd,
                       output logic ev, output logic [2:0] es);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        rv = rsp_valid; rd = rsp_data; ev = evt_valid; es = evt_src;
    endtask

    task automatic ld(input logic [15:0] a, output logic [7:0] rd, output logic rv);
        logic ev; logic [2:0] es;
        acc(1'b0, a, rv, rd, ev, es);
    endtask

    task automatic st(input logic [15:0] a, output logic ev, output logic [2:0] es, output logic rv);
        logic [7:0] rd;
        acc(1'b1, a, rv, rd, ev, es);
    endtask

    function automatic int get_pq_dummy(input int x); return x; endfunction

    task automatic peek(input string req, input int src, input int exp);
        logic [7:0] rd; logic rv;
        ld(mk(src, 1'b1, 4'h0), rd, rv);
        chk({req, " rv"}, int'(rv), 1);
        chk({req, " pq"}, int'(rd), exp);
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 evt_valid", int'(evt_valid), 0);
        for (int s = 0; s < 8; s++) peek("R1 off", s, 1);
    endtask

    task automatic t_enable_trigger();
        logic ev; logic [2:0] es; logic rv; logic [7:0] rd;
        st(mk(2, 1'b0, 4'h0), ev, es, rv);
        chk("R7 no evt when off", int'(ev), 0);
        peek("R7 still off", 2, 1);
        ld(mk(2, 1'b1, 4'h8), rd, rv);
        chk("R3 set00 old", int'(rd), 1);
        peek("R3 now 00", 2, 0);
        st(mk(2, 1'b0, 4'h3), ev, es, rv);
        chk("R5 evt", int'(ev), 1);
        chk("R5 evt_src", int'(es), 2);
        chk("R9 store no rsp", int'(rv), 0);
        peek("R5 pending", 2, 2);
        peek("R11 neighbour", 3, 1);
    endtask

    task automatic t_coalesce_eoi();
        logic ev; logic [2:0] es; logic rv;
        st(mk(2, 1'b0, 4'h0), ev, es, rv);
        chk("R6 no evt", int'(ev), 0);
        peek("R6 queued", 2, 3);
        st(mk(2, 1'b0, 4'h0), ev, es, rv);
        chk("R6 no evt again", int'(ev), 0);
        peek("R6 stays queued", 2, 3);
        st(mk(2, 1'b1, 4'h4), ev, es, rv);
        chk("R8 requeue evt", int'(ev), 1);
        chk("R8 requeue src", int'(es), 2);
        peek("R8 back to pending", 2, 2);
        st(mk(2, 1'b1, 4'h4), ev, es, rv);
        chk("R8 no evt", int'(ev), 0);
        peek("R8 reset", 2, 0);
        st(mk(2, 1'b1, 4'h4), ev, es, rv);
        chk("R8 eoi on 00 no evt", int'(ev), 0);
        peek("R8 eoi on 00", 2, 0);
    endtask

    task automatic t_set_and_ignore();
        logic ev; logic [2:0] es; logic rv; logic [7:0] rd;
        ld(mk(7, 1'b1, 4'hB), rd, rv);
        chk("R3 set11 old", int'(rd), 1);
        ld(mk(7, 1'b1, 4'h2), rd, rv);
        chk("R4 other op as get", int'(rd), 3);
        ld(mk(7, 1'b1, 4'h9), rd, rv);
        chk("R3 set01 old", int'(rd), 3);
        peek("R3 off again", 7, 1);
        st(mk(7, 1'b1, 4'h4), ev, es, rv);
        chk("R8 eoi on off no evt", int'(ev), 0);
        peek("R8 eoi on off", 7, 1);
        ld(mk(5, 1'b1, 4'hA), rd, rv);
        peek("R3 set10", 5, 2);
        ld(mk(5, 1'b0, 4'h8), rd, rv);
        chk("R9 trig page load rv", int'(rv), 1);
        chk("R9 trig page load data", int'(rd), 0);
        peek("R9 trig page load no effect", 5, 2);
        ld(16'(mk(5, 1'b1, 4'h8) | 16'h0004), rd, rv);
        chk("R2 misaligned load data", int'(rd), 0);
        peek("R2 misaligned no effect", 5, 2);
        st(mk(5, 1'b1, 4'h0), ev, es, rv);
        st(16'(mk(5, 1'b1, 4'h4) | 16'h0010), ev, es, rv);
        chk("R10 ignored store no evt", int'(ev), 0);
        peek("R10 ignored stores", 5, 2);
        peek("R11 src2 untouched", 2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_trigger();
        t_coalesce_eoi();
        t_set_and_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule